// File: doc/BRIEF.md
# Multichip Shared Interrupt Pending Dispatcher

This block sits in one chip of a system where several chips share one space of shared peripheral interrupt IDs. A small ownership table gives each chip a contiguous range of 32-ID blocks, where block b starts at ID 32·b + 32. The block takes set-pending and clear-pending writes for any ID. If the local chip owns the ID, the block updates a local pending array. If another chip owns the ID, the block sends the write over a cross-chip request port to that chip. If no chip owns the ID, the write is rejected.

A configuration bit selects when the write response is returned. With the bit clear, the response comes early. With the bit set, the response waits until the local pending bit has changed, or until the remote owner has acknowledged a forwarded write.

A set-pending write to a local ID also produces a delivery strobe. The strobe names a target chip, taken from either the level-2 or the level-3 affinity field of the request. An interrupt marked for one-of-N delivery always targets the local chip. Edge-triggered interrupt wires are mapped onto the lowest IDs the local chip owns, with a cap of 16 wires per owned block.

Top module: `mc_spi_dispatch`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `rsp_err`, `xc_valid` and `dlv_valid` are 0, every `pend` bit is 0 and every table entry is invalid.
- R2: A set-pending or clear-pending write accepted for a locally owned ID writes 1 or 0 to `pend[id-32]`. The new value is visible in the second cycle after acceptance.
- R3: A write accepted for an ID owned by another chip raises `xc_valid` in the cycle after acceptance. It carries the owner's index on `xc_chip`, the ID on `xc_id` and the set flag on `xc_set`. All of these stay stable until `xc_ready` is sampled high. `xc_chip` never equals `self_chip`.
- R4: A write is rejected in three cases: the ID is below 32, the value id−32 is at least 32·NUM_BLOCKS, or no valid entry owns the ID's block (id−32)>>5. A rejected write gets a one-cycle `rsp_valid` together with `rsp_err` in the cycle after acceptance. It changes no pending bit, sends no cross-chip request and leaves `req_ready` high.
- R5: When `cfg_hold` is 0 at acceptance, a valid write gets a one-cycle `rsp_valid` with `rsp_err` = 0 in the cycle after acceptance. This applies to both local and forwarded writes.
- R6: When `cfg_hold` is 1 at acceptance, the response for a local write comes in the same cycle as the new pending value. For a forwarded write, the response comes in the cycle after `xc_ack` is sampled high. An `xc_ack` sampled at or before the cross-chip handshake edge is ignored.
- R7: A set-pending write to a local ID gives a one-cycle `dlv_valid` in the same cycle as its pending update. `dlv_id` carries the ID. `dlv_chip` is `self_chip` if `req_one_of_n` is 1. Otherwise it is `req_aff2` when `cfg_aff3` is 0, or `req_aff3` when `cfg_aff3` is 1. A clear-pending write gives no strobe.
- R8: A wire i that is sampled high after being sampled low sets `pend[32·min+i]` at that same clock edge. Here min is the local entry's first block, so the bit is interrupt ID 32·min+32+i. A wire that stays high does not set the bit again. If a wire set and a clear-pending update hit the same bit at the same edge, the set wins.
- R9: Wire i has no effect in two cases: i is at least 16·(max−min+1) of the local entry, or the local entry is invalid or has max < min.
- R10: The table write port replaces entry `tbl_sel` at the next edge. When entries overlap, the lowest chip index owns the block.
- R11: Only one write is in flight at a time. `req_ready` is low from acceptance until the write completes. A local write completes one cycle after acceptance. A forwarded write completes at the handshake edge when `cfg_hold` was 0, or with its response when it was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_chip | input | CHIP_W | Index of this chip |
| cfg_hold | input | 1 | 1 = hold response until the update is done |
| cfg_aff3 | input | 1 | 1 = target from level-3 affinity field, 0 = level 2 |
| tbl_we | input | 1 | Ownership table write strobe |
| tbl_sel | input | CHIP_W | Entry being written |
| tbl_vld | input | 1 | Valid flag for the written entry |
| tbl_min | input | BLK_W | First owned block |
| tbl_max | input | BLK_W | Last owned block |
| req_valid | input | 1 | Pending write request |
| req_ready | output | 1 | Request can be accepted |
| req_id | input | ID_W | Interrupt ID |
| req_set | input | 1 | 1 = set pending, 0 = clear pending |
| req_one_of_n | input | 1 | Interrupt uses one-of-N delivery |
| req_aff2 | input | CHIP_W | Chip field of affinity level 2 |
| req_aff3 | input | CHIP_W | Chip field of affinity level 3 |
| rsp_valid | output | 1 | Write response strobe |
| rsp_err | output | 1 | Response is an error |
| xc_valid | output | 1 | Cross-chip request valid |
| xc_ready | input | 1 | Cross-chip request accepted |
| xc_chip | output | CHIP_W | Destination (owner) chip |
| xc_id | output | ID_W | Forwarded interrupt ID |
| xc_set | output | 1 | Forwarded set/clear flag |
| xc_ack | input | 1 | Remote owner acknowledge strobe |
| wire_in | input | NUM_WIRES | Edge-triggered interrupt wires |
| dlv_valid | output | 1 | Delivery strobe for a local set |
| dlv_chip | output | CHIP_W | Delivery target chip |
| dlv_id | output | ID_W | Delivered interrupt ID |
| pend | output | 32·NUM_BLOCKS | Local pending array, bit k = ID k+32 |

## Verification
Each result has a fixed due cycle, counted from the edge that accepts a write. A response or error is due one cycle later. A pending update and its delivery strobe are due two cycles later. A held response for a forwarded write is due one cycle after the acknowledge edge. A wire edge updates pending in the cycle right after the edge where the wire is first seen high. The bench keeps a behavioural model that advances on the same rising edges as the design, and it compares every output with the model on each falling edge, so a result that comes one cycle early or late is reported. Directed checks sample at those same falling edges for the reset state, the wire limits and table overlap.

// File: rtl/mc_spi_dispatch.sv
module mc_spi_dispatch #(
  parameter int NUM_CHIPS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int NUM_WIRES  = 64,
  parameter int ID_W       = 10,
  localparam int CHIP_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
  localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int NPEND  = NUM_BLOCKS * 32,
  localparam int PIDX_W = $clog2(NPEND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHIP_W-1:0] self_chip,
  input  logic              cfg_hold,
  input  logic              cfg_aff3,
  input  logic              tbl_we,
  input  logic [CHIP_W-1:0] tbl_sel,
  input  logic              tbl_vld,
  input  logic [BLK_W-1:0]  tbl_min,
  input  logic [BLK_W-1:0]  tbl_max,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_set,
  input  logic              req_one_of_n,
  input  logic [CHIP_W-1:0] req_aff2,
  input  logic [CHIP_W-1:0] req_aff3,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              xc_valid,
  input  logic              xc_ready,
  output logic [CHIP_W-1:0] xc_chip,
  output logic [ID_W-1:0]   xc_id,
  output logic              xc_set,
  input  logic              xc_ack,
  input  logic [NUM_WIRES-1:0] wire_in,
  output logic              dlv_valid,
  output logic [CHIP_W-1:0] dlv_chip,
  output logic [ID_W-1:0]   dlv_id,
  output logic [NPEND-1:0]  pend
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOC, ST_FWD, ST_ACKW} st_t;
  st_t st;

  logic [NUM_CHIPS-1:0] t_vld;
  logic [BLK_W-1:0]     t_min [NUM_CHIPS];
  logic [BLK_W-1:0]     t_max [NUM_CHIPS];

  logic [ID_W-1:0]   s_id;
  logic              s_set, s_hold;
  logic [CHIP_W-1:0] s_chip;
  logic [NUM_WIRES-1:0] wire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_vld <= '0;
      for (int c = 0; c < NUM_CHIPS; c++) begin
        t_min[c] <= '0;
        t_max[c] <= '0;
      end
    end else if (tbl_we) begin
      t_vld[tbl_sel] <= tbl_vld;
      t_min[tbl_sel] <= tbl_min;
      t_max[tbl_sel] <= tbl_max;
    end
  end

  logic [ID_W-1:0]  rel;
  logic [BLK_W-1:0] rblk;
  logic             in_rng, hit;
  logic [CHIP_W-1:0] own;

  assign rel    = req_id - ID_W'(32);
  assign in_rng = (req_id >= ID_W'(32)) && (int'(rel) < NPEND);
  assign rblk   = rel[5 +: BLK_W];

  always_comb begin
    hit = 1'b0;
    own = '0;
    for (int c = NUM_CHIPS - 1; c >= 0; c--) begin
      if (t_vld[c] && rblk >= t_min[c] && rblk <= t_max[c]) begin
        hit = 1'b1;
        own = CHIP_W'(c);
      end
    end
  end

  logic              req_ok;
  logic [CHIP_W-1:0] dchip;
  assign req_ok = in_rng && hit;
  assign dchip  = req_one_of_n ? self_chip : (cfg_aff3 ? req_aff3 : req_aff2);

  logic [NUM_WIRES-1:0] rise;
  logic [NPEND-1:0]     wset;
  assign rise = wire_in & ~wire_q;

  always_comb begin
    int base, lim;
    wset = '0;
    base = int'(t_min[self_chip]) * 32;
    lim  = 0;
    if (t_vld[self_chip] && t_max[self_chip] >= t_min[self_chip])
      lim = 16 * (int'(t_max[self_chip]) - int'(t_min[self_chip]) + 1);
    for (int i = 0; i < NUM_WIRES; i++)
      if (rise[i] && i < lim && base + i < NPEND)
        wset[PIDX_W'(base + i)] = 1'b1;
  end

  logic [ID_W-1:0]  s_rel;
  logic [NPEND-1:0] pend_nx;
  assign s_rel = s_id - ID_W'(32);

  always_comb begin
    pend_nx = pend;
    if (st == ST_LOC)
      for (int k = 0; k < NPEND; k++)
        if (k == int'(s_rel)) pend_nx[k] = s_set;
    pend_nx = pend_nx | wset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      wire_q <= '0;
    end else begin
      pend   <= pend_nx;
      wire_q <= wire_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      s_id      <= '0;
      s_set     <= 1'b0;
      s_hold    <= 1'b0;
      s_chip    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      dlv_valid <= 1'b0;
      dlv_chip  <= '0;
      dlv_id    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      dlv_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          if (!req_ok) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
          end else begin
            s_id   <= req_id;
            s_set  <= req_set;
            s_hold <= cfg_hold;
            if (!cfg_hold) rsp_valid <= 1'b1;
            if (own == self_chip) begin
              s_chip <= dchip;
              st     <= ST_LOC;
            end else begin
              s_chip <= own;
              st     <= ST_FWD;
            end
          end
        end
        ST_LOC: begin
          st <= ST_IDLE;
          if (s_hold) rsp_valid <= 1'b1;
          if (s_set) begin
            dlv_valid <= 1'b1;
            dlv_chip  <= s_chip;
            dlv_id    <= s_id;
          end
        end
        ST_FWD: if (xc_ready) st <= s_hold ? ST_ACKW : ST_IDLE;
        ST_ACKW: if (xc_ack) begin
          rsp_valid <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign xc_valid  = (st == ST_FWD);
  assign xc_chip   = s_chip;
  assign xc_id     = s_id;
  assign xc_set    = s_set;

endmodule

module mc_spi_dispatch_chk #(
  parameter int CHIP_W = 2,
  parameter int ID_W   = 10,
  parameter int NPEND  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CHIP_W-1:0] self_chip,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              xc_valid,
  input logic              xc_ready,
  input logic [CHIP_W-1:0] xc_chip,
  input logic [ID_W-1:0]   xc_id,
  input logic              xc_set,
  input logic              dlv_valid,
  input logic [ID_W-1:0]   dlv_id,
  input logic [NPEND-1:0]  pend
);

  logic dlv_hit;
  always_comb begin
    dlv_hit = 1'b0;
    for (int k = 0; k < NPEND; k++)
      if (k == int'(dlv_id) - 32) dlv_hit = pend[k];
  end

  AST_XC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    xc_valid && !xc_ready |=> xc_valid && $stable(xc_chip) && $stable(xc_id) && $stable(xc_set)); // R3
  AST_XC_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    xc_valid |-> xc_chip != self_chip); // R3
  AST_XC_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xc_valid |-> !req_ready); // R11
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid && req_ready); // R4
  AST_XC_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    xc_valid |-> xc_id >= ID_W'(32)); // R4
  AST_DLV_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> dlv_hit); // R2

endmodule

bind mc_spi_dispatch mc_spi_dispatch_chk #(
  .CHIP_W(CHIP_W), .ID_W(ID_W), .NPEND(NPEND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .self_chip(self_chip), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .xc_valid(xc_valid),
  .xc_ready(xc_ready), .xc_chip(xc_chip), .xc_id(xc_id), .xc_set(xc_set),
  .dlv_valid(dlv_valid), .dlv_id(dlv_id), .pend(pend)
);

// File: tb/mc_spi_dispatch_bench.sv
module mc_spi_dispatch_bench;
  localparam int NC = 4, NB = 8, NW = 64, IW = 10, NP = 256, CW = 2, BW = 3;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] self_chip = 2'd1;
  logic cfg_hold = 0, cfg_aff3 = 0;
  logic tbl_we = 0, tbl_vld = 0;
  logic [CW-1:0] tbl_sel = 0;
  logic [BW-1:0] tbl_min = 0, tbl_max = 0;
  logic req_valid = 0, req_set = 0, req_one_of_n = 0;
  logic [IW-1:0] req_id = 0;
  logic [CW-1:0] req_aff2 = 0, req_aff3 = 0;
  logic xc_ready = 0, xc_ack = 0;
  logic [NW-1:0] wire_in = 0;
  logic req_ready, rsp_valid, rsp_err, xc_valid, xc_set, dlv_valid;
  logic [CW-1:0] xc_chip, dlv_chip;
  logic [IW-1:0] xc_id, dlv_id;
  logic [NP-1:0] pend;

  mc_spi_dispatch #(.NUM_CHIPS(NC), .NUM_BLOCKS(NB), .NUM_WIRES(NW), .ID_W(IW)) u_mc_spi_dispatch (
    .clk(clk), .rst_n(rst_n), .self_chip(self_chip), .cfg_hold(cfg_hold), .cfg_aff3(cfg_aff3),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_vld(tbl_vld), .tbl_min(tbl_min), .tbl_max(tbl_max),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_set(req_set),
    .req_one_of_n(req_one_of_n), .req_aff2(req_aff2), .req_aff3(req_aff3),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .xc_valid(xc_valid), .xc_ready(xc_ready),
    .xc_chip(xc_chip), .xc_id(xc_id), .xc_set(xc_set), .xc_ack(xc_ack), .wire_in(wire_in),
    .dlv_valid(dlv_valid), .dlv_chip(dlv_chip), .dlv_id(dlv_id), .pend(pend));

  always #10 clk = ~clk;

  int vecs = 0, miss = 0;
  bit cmp_on = 0, rnd_hs = 1;

  task automatic chk1(string r, logic a, logic e);
    vecs++;
    if (a !== e) begin miss++; $display("FAIL %s actual=%b expected=%b", r, a, e); end
  endtask
  task automatic chkn(string r, int a, int e);
    vecs++;
    if (a != e) begin miss++; $display("FAIL %s actual=%0d expected=%0d", r, a, e); end
  endtask
  task automatic chkp(string r, logic [NP-1:0] a, logic [NP-1:0] e);
    vecs++;
    if (a !== e) begin miss++; $display("FAIL %s actual=%h expected=%h", r, a, e); end
  endtask

  // behavioural reference model
  bit [NP-1:0] m_pend;
  int m_st, m_id, m_chip, m_dchip, m_did;
  bit m_set, m_hold, m_rsp, m_err, m_dlv;
  bit [NW-1:0] m_wq;
  bit mt_vld[NC];
  int mt_min[NC], mt_max[NC];

  function automatic int owner(int id);
    int b;
    if (id < 32 || id - 32 >= NP) return -1;
    b = (id - 32) / 32;
    for (int c = 0; c < NC; c++)
      if (mt_vld[c] && b >= mt_min[c] && b <= mt_max[c]) return c;
    return -1;
  endfunction

  always @(posedge clk) begin
    int o, me, lim;
    bit [NW-1:0] rise;
    me = int'(self_chip);
    if (!rst_n) begin
      m_pend = '0; m_st = 0; m_rsp = 0; m_err = 0; m_dlv = 0; m_wq = '0;
      m_id = 0; m_chip = 0; m_set = 0; m_hold = 0; m_dchip = 0; m_did = 0;
      for (int c = 0; c < NC; c++) begin mt_vld[c] = 0; mt_min[c] = 0; mt_max[c] = 0; end
    end else begin
      m_rsp = 0; m_err = 0; m_dlv = 0;
      rise = wire_in & ~m_wq;
      m_wq = wire_in;
      case (m_st)
        0: if (req_valid) begin
          o = owner(int'(req_id));
          if (o < 0) begin m_rsp = 1; m_err = 1; end
          else begin
            m_id = int'(req_id); m_set = req_set; m_hold = cfg_hold;
            if (!cfg_hold) m_rsp = 1;
            if (o == me) begin
              m_chip = req_one_of_n ? me : (cfg_aff3 ? int'(req_aff3) : int'(req_aff2));
              m_st = 1;
            end else begin
              m_chip = o; m_st = 2;
            end
          end
        end
        1: begin
          m_pend[m_id - 32] = m_set;
          if (m_hold) m_rsp = 1;
          if (m_set) begin m_dlv = 1; m_dchip = m_chip; m_did = m_id; end
          m_st = 0;
        end
        2: if (xc_ready) m_st = m_hold ? 3 : 0;
        3: if (xc_ack) begin m_rsp = 1; m_st = 0; end
        default: m_st = 0;
      endcase
      if (mt_vld[me] && mt_max[me] >= mt_min[me]) begin
        lim = 16 * (mt_max[me] - mt_min[me] + 1);
        for (int i = 0; i < NW; i++)
          if (rise[i] && i < lim && mt_min[me] * 32 + i < NP) m_pend[mt_min[me] * 32 + i] = 1;
      end
      if (tbl_we) begin
        mt_vld[tbl_sel] = tbl_vld; mt_min[tbl_sel] = int'(tbl_min); mt_max[tbl_sel] = int'(tbl_max);
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk1("R11", req_ready, m_st == 0);
      chk1("R3", xc_valid, m_st == 2);
      if (m_st == 2) begin
        chkn("R3", int'(xc_chip), m_chip);
        chkn("R3", int'(xc_id), m_id);
        chk1("R3", xc_set, m_set);
      end
      chk1(m_hold ? "R6" : "R5", rsp_valid, m_rsp);
      chk1("R4", rsp_err, m_err);
      chk1("R7", dlv_valid, m_dlv);
      if (m_dlv) begin
        chkn("R7", int'(dlv_chip), m_dchip);
        chkn("R7", int'(dlv_id), m_did);
      end
      chkp("R2", pend, m_pend);
    end
    if (rst_n && rnd_hs) begin
      xc_ready = ($urandom % 3) != 0;
      xc_ack   = ($urandom % 4) == 0;
    end else begin
      xc_ready = 0; xc_ack = 0;
    end
  end

  task automatic twrite(int c, bit v, int mn, int mx);
    @(negedge clk);
    tbl_we = 1; tbl_sel = CW'(c); tbl_vld = v; tbl_min = BW'(mn); tbl_max = BW'(mx);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic send(int id, bit s, bit one, int a2, int a3);
    @(negedge clk);
    req_valid = 1; req_id = IW'(id); req_set = s; req_one_of_n = one;
    req_aff2 = CW'(a2); req_aff3 = CW'(a3);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!req_ready);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp_on = 1;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chkp("R1", pend, '0);
    chk1("R1", req_ready, 1'b1);
    chk1("R1", xc_valid | rsp_valid | dlv_valid, 1'b0);

    twrite(0, 1, 0, 1);
    twrite(1, 1, 2, 4);
    twrite(2, 1, 5, 6);

    // local set, early response, level-2 target
    cfg_hold = 0; cfg_aff3 = 0;
    send(101, 1, 0, 2, 3);
    chk1("R5", rsp_valid, 1'b1);
    @(negedge clk);
    chk1("R2", pend[69], 1'b1);
    chk1("R7", dlv_valid, 1'b1);
    chkn("R7", int'(dlv_chip), 2);
    wait_idle();

    // local clear, held response
    cfg_hold = 1;
    send(101, 0, 0, 2, 3);
    chk1("R6", rsp_valid, 1'b0);
    @(negedge clk);
    chk1("R6", rsp_valid, 1'b1);
    chk1("R2", pend[69], 1'b0);
    chk1("R7", dlv_valid, 1'b0);
    wait_idle();

    // one-of-N stays local, level-3 selected
    cfg_hold = 0; cfg_aff3 = 1;
    send(110, 1, 1, 2, 3);
    @(negedge clk);
    chkn("R7", int'(dlv_chip), 1);
    wait_idle();
    send(111, 1, 0, 2, 3);
    @(negedge clk);
    chkn("R7", int'(dlv_chip), 3);
    wait_idle();

    // errors
    send(10, 1, 0, 0, 0);
    chk1("R4", rsp_err, 1'b1);
    chk1("R4", xc_valid, 1'b0);
    send(256, 1, 0, 0, 0);
    chk1("R4", rsp_err, 1'b1);
    send(300, 1, 0, 0, 0);
    chk1("R4", rsp_err, 1'b1);
    wait_idle();

    // forwarding with both response modes
    cfg_hold = 0;
    send(40, 1, 0, 0, 0);
    chk1("R3", xc_valid, 1'b1);
    chkn("R3", int'(xc_chip), 0);
    wait_idle();
    cfg_hold = 1;
    send(200, 0, 0, 0, 0);
    chkn("R3", int'(xc_chip), 2);
    chk1("R6", rsp_valid, 1'b0);
    wait_idle();

    // wires
    @(negedge clk); wire_in[0] = 1; wire_in[47] = 1; wire_in[48] = 1;
    @(negedge clk);
    chk1("R8", pend[64], 1'b1);
    chk1("R8", pend[111], 1'b1);
    chk1("R9", pend[112], 1'b0);
    cfg_hold = 0;
    send(96, 0, 0, 0, 0);
    wait_idle();
    chk1("R8", pend[64], 1'b0);
    @(negedge clk); wire_in = '0;
    twrite(1, 0, 2, 4);
    @(negedge clk); wire_in[1] = 1;
    @(negedge clk);
    chk1("R9", pend[65], 1'b0);
    wire_in = '0;
    twrite(1, 1, 2, 4);

    // overlap: lowest index wins
    twrite(3, 1, 1, 7);
    send(65, 1, 0, 0, 0);
    chkn("R10", int'(xc_chip), 0);
    wait_idle();
    send(256, 1, 0, 0, 0);
    chkn("R10", int'(xc_chip), 3);
    wait_idle();

    // random mix
    for (int k = 0; k < 400; k++) begin
      cfg_hold = $urandom % 2;
      cfg_aff3 = $urandom % 2;
      if ($urandom % 5 == 0) wire_in = {$urandom, $urandom};
      send(20 + int'($urandom % 280), $urandom % 2, $urandom % 2, $urandom % 4, $urandom % 4);
      if (k == 200) begin wait_idle(); twrite(3, 0, 0, 0); twrite(0, 1, 0, 0); end
    end
    wait_idle();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule